// File: doc/BRIEF.md
# Blocking Multistage Processor-to-Memory Switch

This block connects N processor request ports to N memory module ports through log2(N) columns of 2x2 switch elements. The columns are joined by a perfect-shuffle wiring. Each request carries a destination module index. Each column steers a request on one bit of that index, starting from the most significant bit. Bit value 0 selects the upper output of an element and bit value 1 selects the lower output. Each of the two inputs of an element steers itself independently.

When both inputs of an element want the same output in the same cycle, one of them passes and the other is dropped. The processor whose request was dropped sees a reject in that same cycle. Each element keeps a one-bit turn pointer that decides which input wins. The pointer flips after every clash in that element, so neither input can starve. Apart from these pointers the network is purely combinational. A request is answered with a grant or a reject in the cycle it is presented. Retrying a rejected request is left to the processors.

Top module: `msnSwitchNet`

## Requirements
- R1: A granted request from processor p with destination d appears on memory port d in the same cycle. That port shows memValid=1, memSrc=p, and the request's write flag and payload unchanged.
- R2: In every cycle, a processor with reqValid=1 sees exactly one of reqGrant and reqReject high. A processor with reqValid=0 sees both low.
- R3: Every memory port with memValid=1 carries a request from a processor that is valid and granted this cycle. The number of valid memory ports equals the number of grants. A rejected request never reaches a memory port.
- R4: A request that is the only valid request in its cycle is always granted, whatever its source and destination.
- R5: If every processor p requests destination (p + c) mod N for a fixed shift c, all N requests are granted in the same cycle.
- R6: When exactly two processors request the same destination in a cycle, exactly one of them is granted.
- R7: When the same two processors keep requesting the same destination on consecutive cycles, the granted processor alternates from cycle to cycle.
- R8: After reset, and in any cycle with no valid request, all grant, reject and memory-valid outputs are low.
- R9: A turn pointer changes only in cycles where its element sees a clash. A contention, then cycles without a clash, then the same contention again grants the processor that lost the earlier contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; turn pointers update on the rising edge |
| rstN | input | 1 | Active-low asynchronous reset; all turn pointers favour the upper input |
| reqValid | input | N | Request present, one bit per processor |
| reqDest | input | N*log2(N) | Destination module index per processor |
| reqWrite | input | N | Write flag per processor |
| reqPayload | input | N*PW | Address/data payload per processor |
| reqGrant | output | N | Request reached its memory port this cycle |
| reqReject | output | N | Request was dropped at some column this cycle |
| memValid | output | N | A request arrives at this memory port |
| memSrc | output | N*log2(N) | Index of the processor whose request arrives |
| memWrite | output | N | Write flag of the arriving request |
| memPayload | output | N*PW | Payload of the arriving request |

## Verification
The grant, reject and memory-port outputs are combinational, so they are due in the same cycle the request is driven. The bench drives its inputs on the falling edge and samples 2 ns later, before the next rising edge. Only the turn pointers act one cycle late: a clash seen in one cycle changes the winner of the next clash in that element. The fairness checks therefore compare winners of successive cycles with no rising edge skipped or added between them. Expected grants and arrivals are derived from the driven destinations and payloads alone. They come from per-port bookkeeping and from properties of the request pattern, such as a lone request or a cyclic shift, with no model of the switch.

// File: rtl/msnPkg.sv
package msnPkg;

  // Strobe from control to one switch element: which input wins a clash.
  typedef struct packed {
    logic favorB;
  } swCtl_t;

  // Report from one switch element back to control.
  typedef struct packed {
    logic clash;
  } swStat_t;

  // Inverse perfect shuffle: the line that lands on position p
  // after a left rotation of the index bits.
  function automatic int unsigned rotR(int unsigned p, int unsigned bits);
    int unsigned mask;
    if (bits <= 1) return p;
    mask = (1 << bits) - 1;
    return ((p >> 1) | ((p & 1) << (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/msnSwitchElem.sv
module msnSwitchElem
  import msnPkg::*;
#(
  parameter int BW = 8
) (
  input  logic          aVld,
  input  logic          aDir,
  input  logic [BW-1:0] aBus,
  input  logic          bVld,
  input  logic          bDir,
  input  logic [BW-1:0] bBus,
  input  swCtl_t        ctl,
  output logic          upVld,
  output logic [BW-1:0] upBus,
  output logic          loVld,
  output logic [BW-1:0] loBus,
  output swStat_t       stat
);

  logic clash;
  logic aPass;
  logic bPass;

  assign clash = aVld & bVld & (aDir == bDir);
  assign aPass = aVld & ~(clash & ctl.favorB);
  assign bPass = bVld & ~(clash & ~ctl.favorB);
  assign stat.clash = clash;

  always_comb begin
    upVld = 1'b0;
    upBus = '0;
    if (aPass && !aDir) begin
      upVld = 1'b1;
      upBus = aBus;
    end else if (bPass && !bDir) begin
      upVld = 1'b1;
      upBus = bBus;
    end
  end

  always_comb begin
    loVld = 1'b0;
    loBus = '0;
    if (aPass && aDir) begin
      loVld = 1'b1;
      loBus = aBus;
    end else if (bPass && bDir) begin
      loVld = 1'b1;
      loBus = bBus;
    end
  end

endmodule

// File: rtl/msnDatapath.sv
module msnDatapath
  import msnPkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 16,
  localparam int IW = $clog2(N),
  localparam int NE = IW * (N / 2)
) (
  input  logic [N-1:0]          reqValid,
  input  logic [N-1:0][IW-1:0]  reqDest,
  input  logic [N-1:0]          reqWrite,
  input  logic [N-1:0][PW-1:0]  reqPayload,
  input  swCtl_t [NE-1:0]       ctl,
  output swStat_t [NE-1:0]      stat,
  output logic [N-1:0]          reqGrant,
  output logic [N-1:0]          memValid,
  output logic [N-1:0][IW-1:0]  memSrc,
  output logic [N-1:0]          memWrite,
  output logic [N-1:0][PW-1:0]  memPayload
);

  localparam int L    = IW;
  localparam int HALF = N / 2;
  // line layout: {dest, src, write, payload}
  localparam int BW   = 2 * IW + 1 + PW;

  logic [L:0][N-1:0]         lnVld;
  logic [L:0][N-1:0][BW-1:0] lnBus;
  logic [N-1:0][IW-1:0]      arriveDest;

  for (genvar i = 0; i < N; i++) begin : g_inject
    assign lnVld[0][i] = reqValid[i];
    assign lnBus[0][i] = {reqDest[i], IW'(i), reqWrite[i], reqPayload[i]};
  end

  for (genvar k = 0; k < L; k++) begin : g_stage
    for (genvar e = 0; e < HALF; e++) begin : g_elem
      localparam int SA = int'(rotR(2 * e, L));
      localparam int SB = int'(rotR(2 * e + 1, L));
      msnSwitchElem #(.BW(BW)) u_elem (
        .aVld  (lnVld[k][SA]),
        .aDir  (lnBus[k][SA][BW-1-k]),
        .aBus  (lnBus[k][SA]),
        .bVld  (lnVld[k][SB]),
        .bDir  (lnBus[k][SB][BW-1-k]),
        .bBus  (lnBus[k][SB]),
        .ctl   (ctl[k*HALF+e]),
        .upVld (lnVld[k+1][2*e]),
        .upBus (lnBus[k+1][2*e]),
        .loVld (lnVld[k+1][2*e+1]),
        .loBus (lnBus[k+1][2*e+1]),
        .stat  (stat[k*HALF+e])
      );
    end
  end

  for (genvar m = 0; m < N; m++) begin : g_eject
    assign memValid[m]   = lnVld[L][m];
    assign arriveDest[m] = lnBus[L][m][BW-1 -: IW];
    assign memSrc[m]     = lnBus[L][m][BW-IW-1 -: IW];
    assign memWrite[m]   = lnBus[L][m][PW];
    assign memPayload[m] = lnBus[L][m][PW-1:0];
  end

  always_comb begin
    reqGrant = '0;
    for (int m = 0; m < N; m++) begin
      if (memValid[m] && arriveDest[m] == IW'(m)) reqGrant[memSrc[m]] = 1'b1;
    end
  end

endmodule

// File: rtl/msnControl.sv
module msnControl
  import msnPkg::*;
#(
  parameter int NE = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  swStat_t [NE-1:0]  stat,
  output swCtl_t  [NE-1:0]  ctl
);

  logic [NE-1:0] favorQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      favorQ <= '0;
    end else begin
      for (int e = 0; e < NE; e++) begin
        if (stat[e].clash) favorQ[e] <= ~favorQ[e];
      end
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_ctl
    assign ctl[e].favorB = favorQ[e];
  end

endmodule

// File: rtl/msnSwitchNet.sv
module msnSwitchNet
  import msnPkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 16,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         reqValid,
  input  logic [N-1:0][IW-1:0] reqDest,
  input  logic [N-1:0]         reqWrite,
  input  logic [N-1:0][PW-1:0] reqPayload,
  output logic [N-1:0]         reqGrant,
  output logic [N-1:0]         reqReject,
  output logic [N-1:0]         memValid,
  output logic [N-1:0][IW-1:0] memSrc,
  output logic [N-1:0]         memWrite,
  output logic [N-1:0][PW-1:0] memPayload
);

  localparam int NE = IW * (N / 2);

  swCtl_t  [NE-1:0] ctl;
  swStat_t [NE-1:0] stat;

  msnControl #(.NE(NE)) u_ctl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .ctl  (ctl)
  );

  msnDatapath #(.N(N), .PW(PW)) u_dp (
    .reqValid   (reqValid),
    .reqDest    (reqDest),
    .reqWrite   (reqWrite),
    .reqPayload (reqPayload),
    .ctl        (ctl),
    .stat       (stat),
    .reqGrant   (reqGrant),
    .memValid   (memValid),
    .memSrc     (memSrc),
    .memWrite   (memWrite),
    .memPayload (memPayload)
  );

  assign reqReject = reqValid & ~reqGrant;

endmodule

// File: rtl/msnSwitchNetChk.sv
module msnSwitchNetChk #(
  parameter int N  = 8,
  parameter int PW = 16,
  localparam int IW = $clog2(N)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [N-1:0]         reqValid,
  input logic [N-1:0][IW-1:0] reqDest,
  input logic [N-1:0]         reqWrite,
  input logic [N-1:0][PW-1:0] reqPayload,
  input logic [N-1:0]         reqGrant,
  input logic [N-1:0]         reqReject,
  input logic [N-1:0]         memValid,
  input logic [N-1:0][IW-1:0] memSrc,
  input logic [N-1:0]         memWrite,
  input logic [N-1:0][PW-1:0] memPayload
);

  p_disjoint_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & reqReject) == '0);

  p_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant | reqReject) == reqValid);

  p_arrivals_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(memValid) == $countones(reqGrant));

  p_lone_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(reqValid) == 1 |-> reqGrant == reqValid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid == '0 |-> (memValid == '0 && reqGrant == '0));

  for (genvar m = 0; m < N; m++) begin : g_port
    p_dest_r1: assert property (@(posedge clk) disable iff (!rstN)
      memValid[m] |-> (reqValid[memSrc[m]] && reqDest[memSrc[m]] == IW'(m)));

    p_data_r1: assert property (@(posedge clk) disable iff (!rstN)
      memValid[m] |-> (memPayload[m] == reqPayload[memSrc[m]] &&
                       memWrite[m] == reqWrite[memSrc[m]]));

    p_from_granted_r3: assert property (@(posedge clk) disable iff (!rstN)
      memValid[m] |-> reqGrant[memSrc[m]]);
  end

endmodule

bind msnSwitchNet msnSwitchNetChk #(.N(N), .PW(PW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqDest    (reqDest),
  .reqWrite   (reqWrite),
  .reqPayload (reqPayload),
  .reqGrant   (reqGrant),
  .reqReject  (reqReject),
  .memValid   (memValid),
  .memSrc     (memSrc),
  .memWrite   (memWrite),
  .memPayload (memPayload)
);

// File: tb/tb_msnSwitchNet.sv
`timescale 1ns/1ps
module tb_msnSwitchNet;

  localparam int N  = 8;
  localparam int PW = 16;
  localparam int IW = $clog2(N);

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [N-1:0]         reqValid;
  logic [N-1:0][IW-1:0] reqDest;
  logic [N-1:0]         reqWrite;
  logic [N-1:0][PW-1:0] reqPayload;
  logic [N-1:0]         reqGrant;
  logic [N-1:0]         reqReject;
  logic [N-1:0]         memValid;
  logic [N-1:0][IW-1:0] memSrc;
  logic [N-1:0]         memWrite;
  logic [N-1:0][PW-1:0] memPayload;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  msnSwitchNet #(.N(N), .PW(PW)) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqDest(reqDest), .reqWrite(reqWrite), .reqPayload(reqPayload),
    .reqGrant(reqGrant), .reqReject(reqReject),
    .memValid(memValid), .memSrc(memSrc), .memWrite(memWrite), .memPayload(memPayload)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearReq();
    reqValid = '0;
    reqDest = '0;
    reqWrite = '0;
    reqPayload = '0;
  endtask

  task automatic setReq(input int p, input int d, input bit w, input logic [PW-1:0] pl);
    reqValid[p] = 1'b1;
    reqDest[p] = IW'(d);
    reqWrite[p] = w;
    reqPayload[p] = pl;
  endtask

  // generic consistency of one cycle: R1, R2, R3
  task automatic evalCycle();
    int nGrant;
    int nMem;
    nGrant = 0;
    nMem = 0;
    for (int p = 0; p < N; p++) begin
      if (reqValid[p])
        chk((reqGrant[p] ^ reqReject[p]) == 1'b1, "R2 one response", {reqGrant[p], reqReject[p]}, 2'b01);
      else
        chk(!reqGrant[p] && !reqReject[p], "R2 idle response", {reqGrant[p], reqReject[p]}, 0);
      if (reqGrant[p]) begin
        nGrant++;
        chk(memValid[reqDest[p]] && memSrc[reqDest[p]] == IW'(p), "R1 arrival port",
            memSrc[reqDest[p]], p);
        chk(memPayload[reqDest[p]] == reqPayload[p] && memWrite[reqDest[p]] == reqWrite[p],
            "R1 payload", memPayload[reqDest[p]], reqPayload[p]);
      end
    end
    for (int m = 0; m < N; m++) begin
      if (memValid[m]) begin
        nMem++;
        chk(reqValid[memSrc[m]] && reqGrant[memSrc[m]] && reqDest[memSrc[m]] == IW'(m),
            "R3 arrival from granted", memSrc[m], m);
      end
    end
    chk(nMem == nGrant, "R3 arrival count", nMem, nGrant);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    int w1;
    int w2;
    clearReq();
    repeat (3) @(negedge clk);
    #2;
    chk(reqGrant == '0 && reqReject == '0 && memValid == '0, "R8 reset outputs",
        {reqGrant, reqReject, memValid}, 0);
    @(negedge clk);
    rstN = 1'b1;
    step();
    #2;
    chk(reqGrant == '0 && reqReject == '0 && memValid == '0, "R8 idle outputs",
        {reqGrant, reqReject, memValid}, 0);

    // R4: every lone request, every destination
    for (int p = 0; p < N; p++) begin
      for (int d = 0; d < N; d++) begin
        step();
        clearReq();
        setReq(p, d, (p + d) % 2 == 1, PW'(16'h1000 * p + 16'h0011 * d));
        #2;
        chk(reqGrant == reqValid, "R4 lone granted", reqGrant, reqValid);
        evalCycle();
      end
    end

    // R5: all cyclic shifts with every port active
    for (int c = 0; c < N; c++) begin
      step();
      clearReq();
      for (int p = 0; p < N; p++) setReq(p, (p + c) % N, p % 2 == 0, PW'(16'h0A00 + 16'h0101 * p + c));
      #2;
      chk(reqGrant == {N{1'b1}}, "R5 shift all granted", reqGrant, {N{1'b1}});
      evalCycle();
    end

    // R6: every pair of processors on every common destination
    for (int d = 0; d < N; d++) begin
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          step();
          clearReq();
          setReq(i, d, 1'b0, PW'(16'hB000 + i));
          setReq(j, d, 1'b1, PW'(16'hC000 + j));
          #2;
          chk($countones(reqGrant) == 1, "R6 one of pair", reqGrant, 1);
          evalCycle();
        end
      end
    end

    // R7 / R9: fairness between processors 2 and 5 aiming at module 3
    step();
    clearReq();
    setReq(2, 3, 1'b0, 16'h2222);
    setReq(5, 3, 1'b1, 16'h5555);
    #2;
    chk($countones(reqGrant) == 1, "R6 contention", reqGrant, 1);
    w1 = reqGrant[2] ? 2 : 5;
    step();
    #2;
    w2 = reqGrant[2] ? 2 : 5;
    chk(w2 != w1 && $countones(reqGrant) == 1, "R7 alternate", w2, (w1 == 2) ? 5 : 2);
    step();
    #2;
    chk(reqGrant[w1] && $countones(reqGrant) == 1, "R7 alternate back", reqGrant, 1 << w1);
    step();
    clearReq();
    setReq(2, 3, 1'b0, 16'h2222);
    #2;
    chk(reqGrant == 8'b0000_0100, "R4 lone between contention", reqGrant, 8'b0000_0100);
    step();
    clearReq();
    #2;
    chk(reqGrant == '0 && memValid == '0, "R8 idle gap", memValid, 0);
    step();
    setReq(2, 3, 1'b0, 16'h2222);
    setReq(5, 3, 1'b1, 16'h5555);
    #2;
    chk(reqGrant[w2] && $countones(reqGrant) == 1, "R9 pointer held", reqGrant, 1 << w2);

    // mixed traffic from a pseudo-random sequence
    for (int t = 0; t < 400; t++) begin
      step();
      clearReq();
      for (int p = 0; p < N; p++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lfsr[0] | lfsr[5]) setReq(p, int'(lfsr[9:7]), lfsr[3], lfsr ^ PW'(t));
      end
      #2;
      evalCycle();
    end

    step();
    clearReq();
    #2;
    chk(reqGrant == '0 && reqReject == '0 && memValid == '0, "R8 final idle",
        {reqGrant, reqReject, memValid}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule